// File: doc/BRIEF.md
# L0 Instruction Buffer with Hit-Driven Level Steering

This block places a small direct-mapped L0 instruction store in front of an L1 instruction cache and decides, fetch by fetch, whether the L0 is worth trying. The decision rests on one predictor bit. A fetch that finds its line in the L0 leaves the bit set, so the next fetch tries the L0 again. A fetch whose line is absent clears the bit, so the next fetch skips the L0 and asks the L1 at once. A bypassed fetch then pays no penalty for a lookup that was likely to fail.

The L0 tags are held apart from the L0 line data. The tag compare therefore runs on every fetch, including fetches sent straight to the L1, and its outcome keeps refreshing the predictor. Each line returned by the L1 is written into the L0 slot that its index selects, and it displaces whatever line was there before.

The CPU side presents one word-aligned fetch address at a time and receives a 32-bit instruction word with a one-cycle valid pulse. The L1 side is a plain request and response port that carries a line-aligned address and returns a whole 16-byte line. Three counters report L0 hits, L0 misses and bypassed fetches, so the steering sequence can be observed from outside.

Top module: `l0_fetch_predictor`

## Requirements
- R1: After reset the predictor selects the L0 (`predL0` = 1), all three counters read 0 and every L0 line is invalid, so the first L0-steered fetch misses.
- R2: An L0-steered fetch whose line is valid with a matching tag raises `rspValid` on the second clock edge after the edge that accepts it. It returns the stored word, increments `hitCnt` and issues no L1 request.
- R3: An L0-steered fetch that misses increments `missCnt` and clears `predL0`. It raises `l1Req` for one cycle only after the extra L0 lookup cycle, and its word appears on the fourth edge after acceptance.
- R4: An L1-steered (bypass) fetch increments `bypassCnt` on the accepting edge and raises `l1Req` in the very next cycle. Its word appears on the third edge after acceptance.
- R5: During a bypass fetch the L0 tag is still compared. A match sets `predL0` and a mismatch leaves it cleared, so the next fetch follows that result.
- R6: Every L1 response is written into the L0. The line index is address bits [IDX_W+3:4], the tag is the bits above the index, and a line held at that index is replaced.
- R7: The returned word is the 32-bit word of the line selected by address bits [3:2]; word k occupies line bits [32k+31:32k].
- R8: `l1Addr` carries the fetch address with bits [3:0] forced to zero.
- R9: `fetchReady` is high only when no fetch is in flight; it is low in the cycle after a fetch is accepted.
- R10: The L0 capacity is the parameter `L0_BYTES` (256 or 512), giving L0_BYTES/16 lines. Two addresses that differ by exactly L0_BYTES share an index and evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch request, taken when fetchReady is high |
| fetchAddr | input | ADDR_W | Byte address of the fetch (bits [1:0] ignored) |
| fetchReady | output | 1 | Block is idle and can take a fetch |
| rspValid | output | 1 | One-cycle pulse: rspData holds the fetched word |
| rspData | output | 32 | Fetched instruction word |
| l1Req | output | 1 | One-cycle line request to the L1 |
| l1Addr | output | ADDR_W | Line-aligned request address |
| l1RespValid | input | 1 | L1 line response valid |
| l1RespLine | input | 128 | Returned 16-byte line, word 0 in the low bits |
| predL0 | output | 1 | Predictor bit: 1 steers the next fetch to the L0 |
| hitCnt | output | CNT_W | L0-steered fetches that hit |
| missCnt | output | CNT_W | L0-steered fetches that missed |
| bypassCnt | output | CNT_W | Fetches sent straight to the L1 |

## Verification
The bench aims at the changes of direction. It covers a miss followed by a bypass that finds its line already present, which must send the next fetch back to the L0; a design that ignored the tag probe on bypassed fetches would stay on the L1 path for good. It also covers two addresses one capacity apart, which must evict each other; a wrong index or tag split would turn that pattern into false hits that return stale words. The bench times every fetch, because a design that skips the extra lookup cycle on a miss, or that waits for the L0 on a bypass, produces the right data at the wrong latency. Word selection within a line is covered by fetching every word of a filled line, since a bad word select returns a neighbouring instruction.

// File: rtl/l0pred_pkg.sv
package l0pred_pkg;

  localparam int LINE_BYTES = 16;
  localparam int WORD_W     = 32;
  localparam int LINE_W     = LINE_BYTES * 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_L0ACC  = 2'd1,
    ST_L1REQ  = 2'd2,
    ST_L1WAIT = 2'd3
  } fetchState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic captureAddr;
    logic fillLine;
    logic deliverL0;
    logic deliverL1;
  } l0Strobes_t;

endpackage

// File: rtl/l0pred_dp.sv
module l0pred_dp
  import l0pred_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L0_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  l0Strobes_t        strobes,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [LINE_W-1:0] l1RespLine,
  output logic              tagHit,
  output logic [ADDR_W-1:0] l1Addr,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData
);

  localparam int NUM_LINES = L0_BYTES / LINE_BYTES;
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int WSEL_W    = OFF_W - 2;
  localparam int WA_W      = ADDR_W - 2;
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W;

  logic [WA_W-1:0]   reqWa;
  logic [WSEL_W-1:0] reqWord;
  logic [IDX_W-1:0]  reqIdx;
  logic [TAG_W-1:0]  reqTag;

  logic [TAG_W-1:0]  tagArr  [NUM_LINES];
  logic [LINE_W-1:0] dataArr [NUM_LINES];
  logic [NUM_LINES-1:0] validArr;

  assign reqWord = reqWa[WSEL_W-1:0];
  assign reqIdx  = reqWa[WSEL_W +: IDX_W];
  assign reqTag  = reqWa[WA_W-1 -: TAG_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqWa <= '0;
    end else if (strobes.captureAddr) begin
      reqWa <= fetchAddr[ADDR_W-1:2];
    end
  end

  // tag array and valid bits, decoupled from line data
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validArr[i] <= 1'b0;
        tagArr[i]   <= '0;
      end else if (strobes.fillLine && reqIdx == IDX_W'(i)) begin
        validArr[i] <= 1'b1;
        tagArr[i]   <= reqTag;
      end
    end

    always_ff @(posedge clk) begin
      if (strobes.fillLine && reqIdx == IDX_W'(i)) begin
        dataArr[i] <= l1RespLine;
      end
    end
  end

  assign tagHit = validArr[reqIdx] && (tagArr[reqIdx] == reqTag);
  assign l1Addr = {reqWa[WA_W-1:WSEL_W], {OFF_W{1'b0}}};

  logic [LINE_W-1:0] l0Line;
  logic [WORD_W-1:0] l0Word;
  logic [WORD_W-1:0] l1Word;

  assign l0Line = dataArr[reqIdx];
  assign l0Word = l0Line[reqWord*WORD_W +: WORD_W];
  assign l1Word = l1RespLine[reqWord*WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobes.deliverL0 | strobes.deliverL1;
      if (strobes.deliverL0) begin
        rspData <= l0Word;
      end else if (strobes.deliverL1) begin
        rspData <= l1Word;
      end
    end
  end

endmodule

// File: rtl/l0pred_ctrl.sv
module l0pred_ctrl
  import l0pred_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchValid,
  input  logic             tagHit,
  input  logic             l1RespValid,
  output l0Strobes_t       strobes,
  output logic             fetchReady,
  output logic             l1Req,
  output logic             predL0,
  output logic [CNT_W-1:0] hitCnt,
  output logic [CNT_W-1:0] missCnt,
  output logic [CNT_W-1:0] bypassCnt
);

  fetchState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (fetchValid) begin
          strobes.captureAddr = 1'b1;
          stateNext = predL0 ? ST_L0ACC : ST_L1REQ;
        end
      end
      ST_L0ACC: begin
        if (tagHit) begin
          strobes.deliverL0 = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          stateNext = ST_L1REQ;
        end
      end
      ST_L1REQ: stateNext = ST_L1WAIT;
      ST_L1WAIT: begin
        if (l1RespValid) begin
          strobes.fillLine  = 1'b1;
          strobes.deliverL1 = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign fetchReady = (state == ST_IDLE);
  assign l1Req      = (state == ST_L1REQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      predL0    <= 1'b1;
      hitCnt    <= '0;
      missCnt   <= '0;
      bypassCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && fetchValid && !predL0) begin
        bypassCnt <= bypassCnt + 1'b1;
      end
      if (state == ST_L0ACC) begin
        if (tagHit) begin
          hitCnt <= hitCnt + 1'b1;
        end else begin
          missCnt <= missCnt + 1'b1;
          predL0  <= 1'b0;
        end
      end
      // tag probe during the L1 request cycle steers the next fetch
      if (state == ST_L1REQ) begin
        predL0 <= tagHit;
      end
    end
  end

endmodule

// File: rtl/l0_fetch_predictor.sv
module l0_fetch_predictor
  import l0pred_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L0_BYTES = 256,
  parameter int CNT_W    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fetchValid,
  input  logic [ADDR_W-1:0]    fetchAddr,
  output logic                 fetchReady,
  output logic                 rspValid,
  output logic [WORD_W-1:0]    rspData,
  output logic                 l1Req,
  output logic [ADDR_W-1:0]    l1Addr,
  input  logic                 l1RespValid,
  input  logic [LINE_W-1:0]    l1RespLine,
  output logic                 predL0,
  output logic [CNT_W-1:0]     hitCnt,
  output logic [CNT_W-1:0]     missCnt,
  output logic [CNT_W-1:0]     bypassCnt
);

  l0Strobes_t strobes;
  logic       tagHit;

  l0pred_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchValid (fetchValid),
    .tagHit     (tagHit),
    .l1RespValid(l1RespValid),
    .strobes    (strobes),
    .fetchReady (fetchReady),
    .l1Req      (l1Req),
    .predL0     (predL0),
    .hitCnt     (hitCnt),
    .missCnt    (missCnt),
    .bypassCnt  (bypassCnt)
  );

  l0pred_dp #(.ADDR_W(ADDR_W), .L0_BYTES(L0_BYTES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .fetchAddr  (fetchAddr),
    .l1RespLine (l1RespLine),
    .tagHit     (tagHit),
    .l1Addr     (l1Addr),
    .rspValid   (rspValid),
    .rspData    (rspData)
  );

endmodule

// File: rtl/l0_fetch_predictor_chk.sv
module l0_fetch_predictor_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             fetchValid,
  input logic             fetchReady,
  input logic             rspValid,
  input logic             l1Req,
  input logic [3:0]       l1AddrLow,
  input logic             predL0,
  input logic [CNT_W-1:0] hitCnt,
  input logic [CNT_W-1:0] missCnt,
  input logic [CNT_W-1:0] bypassCnt
);

  // hit is counted on the same edge the word is delivered, without L1 traffic
  assert_hit_delivers_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hitCnt != $past(hitCnt)) |-> (rspValid && !l1Req));

  // a miss clears the predictor and starts the L1 request
  assert_miss_steers_R3: assert property (@(posedge clk) disable iff (!rstN)
    (missCnt != $past(missCnt)) |-> (l1Req && !predL0));

  // a bypass requests the L1 in the cycle right after acceptance
  assert_bypass_request_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bypassCnt != $past(bypassCnt)) |-> l1Req);

  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    l1Req |=> !l1Req);

  assert_line_aligned_R8: assert property (@(posedge clk) disable iff (!rstN)
    l1Req |-> (l1AddrLow == 4'd0));

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchReady) |=> !fetchReady);

endmodule

bind l0_fetch_predictor l0_fetch_predictor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fetchValid(fetchValid),
  .fetchReady(fetchReady),
  .rspValid  (rspValid),
  .l1Req     (l1Req),
  .l1AddrLow (l1Addr[3:0]),
  .predL0    (predL0),
  .hitCnt    (hitCnt),
  .missCnt   (missCnt),
  .bypassCnt (bypassCnt)
);

// File: tb/l0_fetch_predictor_bench.sv
module l0_fetch_predictor_bench;

  localparam int ADDR_W   = 32;
  localparam int L0_BYTES = 256;
  localparam int CNT_W    = 16;
  localparam int NLINES   = L0_BYTES / 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              fetchValid = 1'b0;
  logic [ADDR_W-1:0] fetchAddr = '0;
  logic              fetchReady;
  logic              rspValid;
  logic [31:0]       rspData;
  logic              l1Req;
  logic [ADDR_W-1:0] l1Addr;
  logic              l1RespValid = 1'b0;
  logic [127:0]      l1RespLine = '0;
  logic              predL0;
  logic [CNT_W-1:0]  hitCnt, missCnt, bypassCnt;

  int testCount = 0;
  int failCount = 0;
  int reqSeen   = 0;
  logic [ADDR_W-1:0] lastReqAddr = '0;

  // bench-side model of the requirements
  logic                  mValid [NLINES];
  logic [ADDR_W-1:0]     mLine  [NLINES];
  logic                  mPred;
  int                    mHit, mMiss, mByp;

  always #5 clk = ~clk;

  l0_fetch_predictor #(.ADDR_W(ADDR_W), .L0_BYTES(L0_BYTES), .CNT_W(CNT_W)) u_l0_fetch_predictor (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchReady(fetchReady), .rspValid(rspValid), .rspData(rspData),
    .l1Req(l1Req), .l1Addr(l1Addr), .l1RespValid(l1RespValid),
    .l1RespLine(l1RespLine), .predL0(predL0), .hitCnt(hitCnt),
    .missCnt(missCnt), .bypassCnt(bypassCnt)
  );

  function automatic logic [31:0] memWord(input logic [ADDR_W-1:0] a);
    logic [29:0] w;
    w = a[ADDR_W-1:2];
    return (32'(w) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [127:0] memLine(input logic [ADDR_W-1:0] a);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) begin
      l[k*32 +: 32] = memWord({a[ADDR_W-1:4], 2'(k), 2'b00});
    end
    return l;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // L1 model: answers in the cycle after it sees a request
  initial begin
    logic pend;
    logic [ADDR_W-1:0] pendAddr;
    pend = 1'b0;
    pendAddr = '0;
    forever begin
      @(negedge clk);
      l1RespValid = 1'b0;
      if (pend) begin
        l1RespValid = 1'b1;
        l1RespLine  = memLine(pendAddr);
        pend = 1'b0;
      end
      if (l1Req) begin
        pend = 1'b1;
        pendAddr = l1Addr;
        reqSeen++;
        lastReqAddr = l1Addr;
      end
    end
  end

  task automatic doFetch(input logic [ADDR_W-1:0] a);
    int lat, expLat, reqBefore, expReq;
    int idx;
    logic hit;
    string kind;
    a[1:0] = 2'b00;
    idx = int'(a[7:4]) % NLINES;
    if (L0_BYTES == 512) idx = int'(a[8:4]);
    hit = mValid[idx] && (mLine[idx] == {a[ADDR_W-1:4], 4'h0});
    if (mPred) begin
      if (hit) begin expLat = 2; mHit++; kind = "R2"; end
      else begin expLat = 4; mMiss++; mPred = 1'b0; kind = "R3"; end
    end else begin
      expLat = 3; mByp++; mPred = hit; kind = "R4";
    end
    expReq = (mPred && hit && expLat == 2) ? 0 : 1;
    if (expLat == 2) expReq = 0;
    if (expLat != 2) begin
      mValid[idx] = 1'b1;
      mLine[idx]  = {a[ADDR_W-1:4], 4'h0};
    end
    while (!fetchReady) @(negedge clk);
    reqBefore = reqSeen;
    fetchValid = 1'b1;
    fetchAddr  = a;
    @(negedge clk);
    fetchValid = 1'b0;
    lat = 1;
    check("R9 ready low after accept", 64'(fetchReady), 64'(0));
    while (!rspValid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check({kind, " latency"}, 64'(lat), 64'(expLat));
    check("R7 R6 word data", 64'(rspData), 64'(memWord(a)));
    check({kind, " L1 requests"}, 64'(reqSeen - reqBefore), 64'(expReq));
    if (expReq != 0) check("R8 line address", 64'(lastReqAddr), 64'({a[ADDR_W-1:4], 4'h0}));
    check("R5 predictor", 64'(predL0), 64'(mPred));
    check("R2 hit count", 64'(hitCnt), 64'(mHit));
    check("R3 miss count", 64'(missCnt), 64'(mMiss));
    check("R4 bypass count", 64'(bypassCnt), 64'(mByp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [ADDR_W-1:0] ra;
    for (int i = 0; i < NLINES; i++) begin mValid[i] = 1'b0; mLine[i] = '0; end
    mPred = 1'b1; mHit = 0; mMiss = 0; mByp = 0;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 predictor after reset", 64'(predL0), 64'(1));
    check("R1 hit count reset", 64'(hitCnt), 64'(0));
    check("R1 miss count reset", 64'(missCnt), 64'(0));
    check("R1 bypass count reset", 64'(bypassCnt), 64'(0));
    check("R1 ready after reset", 64'(fetchReady), 64'(1));

    // R1: first fetch misses; R5: bypass finds the filled line
    doFetch(32'h0000_1040);
    doFetch(32'h0000_1044);
    // R2/R7: every word of the filled line hits
    for (int k = 0; k < 4; k++) doFetch(32'h0000_1040 + 32'(k * 4));
    // R10: alias one capacity away evicts; bypass probe then misses
    doFetch(32'h0000_1040 + 32'(L0_BYTES));
    doFetch(32'h0000_1048);
    doFetch(32'h0000_104C);
    doFetch(32'h0000_1048 + 32'(L0_BYTES));
    doFetch(32'h0000_1048 + 32'(L0_BYTES));

    // random mix over a small footprint
    for (int n = 0; n < 400; n++) begin
      ra = 32'h0000_2000 + 32'($urandom_range(0, 1023) & 32'h3FC);
      doFetch(ra);
    end

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule